// File: doc/BRIEF.md
# Banked Control Register Window Decoder

This block sits between an 8-bit CPU and a banked window that looks into the control and I/O register page of a 16-bit system bus. Each CPU access carries a 16-bit byte offset, a read strobe, a write strobe and a write byte. The upper offset byte picks a register slot. The lower byte picks the byte lane and the register inside that slot. The block then steers the access to one of four places: a small I/O port register file, the bus-request and CPU-reset control bits, an external timing register, or the boot-ROM bank bit.

Slots that are recognised but have nothing behind them read as open bus (all ones), and writes to them are dropped. Slot values outside the recognised set are invalid. An access to one of them reads as open bus and raises a lockup flag that stalls the requesting CPU. The flag stays set until reset. A forced-acknowledge configuration input suppresses the lockup. Address decode and read data are combinational. Only the control bits, the port registers and the lockup flag are registered.

Top module: `cwd_top`

## Requirements
- R1: The slot is given by offset bits 15:8. The recognised values are 0x00, 0x10, 0x11, 0x12, 0x20, 0x30, 0x40, 0x41, 0x44 and 0x50. Any other value is invalid. A read or write to an invalid slot while `cfg_force_ack` is low sets `lockup_o` at the next clock edge. The flag then stays set until reset, and such a read returns 0xFF.
- R2: While `cfg_force_ack` is high, invalid-slot accesses leave `lockup_o` low and still read 0xFF.
- R3: In slot 0x00, a read with offset bits 7:5 equal to zero returns port register number bits 4:1, on either byte lane. Any other read in that slot returns 0xFF.
- R4: In slot 0x00, a write is stored into port register number bits 4:1 only when bits 7:5 are zero and bit 0 is one (odd lane). All other writes in that slot are ignored.
- R5: Slot 0x11 reads 0xFF on both lanes. A write at an even offset loads `busreq_o` from data bit 0 at the next edge. A write at an odd offset is ignored.
- R6: Slot 0x12 reads 0xFF. A write at an even offset loads `zreset_o` from data bit 0 at the next edge. A write at an odd offset is ignored.
- R7: Slot 0x30 reads the high byte of `tmr_value` at an even offset and the low byte at an odd offset when `tmr_present` is high, and 0xFF when it is low. Any write in the slot raises `tmr_wr_stb` in the same cycle.
- R8: Slot 0x41 reads 0xFE OR'd with the bank bit at an odd offset, and 0xFF at an even offset. A write loads `bank_o` from data bit 0 only at an odd offset while `cfg_bootrom_en` is high.
- R9: Slots 0x10, 0x20, 0x40, 0x44 and 0x50 read 0xFF. Writes to them change no register, do not alias onto the port file, and never set `lockup_o`.
- R10: After reset, `busreq_o`, `zreset_o`, `bank_o`, `lockup_o` and all port registers are zero. `acc_rdata` is 0xFF whenever `acc_rd` is low.
- R11: When read and write strobes are both high in one cycle, the read returns the contents from before the write. The write takes effect at that cycle's clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| acc_addr | input | 16 | Byte offset inside the banked window |
| acc_rd | input | 1 | Read strobe |
| acc_wr | input | 1 | Write strobe |
| acc_wdata | input | 8 | Write byte |
| cfg_force_ack | input | 1 | Suppresses lockup on invalid slots |
| cfg_bootrom_en | input | 1 | Allows writes to the boot-ROM bank bit |
| tmr_present | input | 1 | A timing device is fitted |
| tmr_value | input | 16 | Current timing register value |
| acc_rdata | output | 8 | Read data, combinational |
| tmr_wr_stb | output | 1 | Write strobe to the timing device |
| busreq_o | output | 1 | Bus-request control bit |
| zreset_o | output | 1 | CPU reset control bit |
| bank_o | output | 1 | Boot-ROM bank bit |
| lockup_o | output | 1 | Sticky stall indication |

## Verification
A read of a port register and a write to that register can fall in the same cycle, because the CPU side drives both strobes at once. The bench raises both strobes on one odd offset in slot 0x00. It expects the combinational read data to show the old contents, and a following read to show the new byte. A second overlap is an invalid-slot access in a cycle where `cfg_force_ack` is high. The bench judges that case by the open-bus read value in the cycle and by `lockup_o` staying low after the edge.

// File: rtl/cwd_pkg.sv
package cwd_pkg;

  typedef enum logic [2:0] {
    SLOT_IO,
    SLOT_BUSREQ,
    SLOT_RESET,
    SLOT_TIMER,
    SLOT_BOOT,
    SLOT_UNUSED,
    SLOT_INVALID
  } slot_e;

  function automatic slot_e slot_of(input logic [7:0] sel);
    slot_e s;
    case (sel)
      8'h00:                              s = SLOT_IO;
      8'h11:                              s = SLOT_BUSREQ;
      8'h12:                              s = SLOT_RESET;
      8'h30:                              s = SLOT_TIMER;
      8'h41:                              s = SLOT_BOOT;
      8'h10, 8'h20, 8'h40, 8'h44, 8'h50:  s = SLOT_UNUSED;
      default:                            s = SLOT_INVALID;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/cwd_decode.sv
module cwd_decode
  import cwd_pkg::*;
(
  input  logic [7:0] sel,
  input  logic [2:0] sub,
  input  logic       lane_odd,
  input  logic       rd_en,
  input  logic       wr_en,
  input  logic       cfg_force_ack,
  input  logic       cfg_bootrom_en,
  output slot_e      slot,
  output logic       io_rd_ok,
  output logic       io_we,
  output logic       busreq_we,
  output logic       zreset_we,
  output logic       bank_we,
  output logic       tmr_we,
  output logic       lock_req
);

  logic sub_zero;

  always_comb begin
    slot      = slot_of(sel);
    sub_zero  = (sub == 3'b000);
    io_rd_ok  = (slot == SLOT_IO) && sub_zero;
    io_we     = wr_en && (slot == SLOT_IO) && sub_zero && lane_odd;
    busreq_we = wr_en && (slot == SLOT_BUSREQ) && !lane_odd;
    zreset_we = wr_en && (slot == SLOT_RESET) && !lane_odd;
    bank_we   = wr_en && (slot == SLOT_BOOT) && lane_odd && cfg_bootrom_en;
    tmr_we    = wr_en && (slot == SLOT_TIMER);
    lock_req  = (rd_en || wr_en) && (slot == SLOT_INVALID) && !cfg_force_ack;
  end

endmodule

// File: rtl/cwd_ioregs.sv
module cwd_ioregs #(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [IW-1:0] wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic [IW-1:0] rd_idx,
  output logic [DW-1:0] rd_q
);

  logic [DW-1:0] regs [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_port
    logic          hit;
    logic [DW-1:0] nxt;

    always_comb begin
      hit = we && (wr_idx == IW'(g));
      nxt = hit ? wr_data : regs[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) regs[g] <= '0;
      else if (hit) regs[g] <= nxt;
    end
  end

  assign rd_q = regs[rd_idx];

  assert_io_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> regs[$past(wr_idx)] == $past(wr_data));

endmodule

// File: rtl/cwd_ctrl.sv
module cwd_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic busreq_we,
  input  logic zreset_we,
  input  logic bank_we,
  input  logic lock_req,
  input  logic wr_bit,
  output logic busreq_q,
  output logic zreset_q,
  output logic bank_q,
  output logic lockup_q
);

  logic busreq_d, zreset_d, bank_d, lockup_d;

  always_comb begin
    busreq_d = busreq_we ? wr_bit : busreq_q;
    zreset_d = zreset_we ? wr_bit : zreset_q;
    bank_d   = bank_we   ? wr_bit : bank_q;
    lockup_d = lockup_q || lock_req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busreq_q <= 1'b0;
      zreset_q <= 1'b0;
      bank_q   <= 1'b0;
      lockup_q <= 1'b0;
    end else begin
      busreq_q <= busreq_d;
      zreset_q <= zreset_d;
      bank_q   <= bank_d;
      lockup_q <= lockup_d;
    end
  end

  assert_bank_guard_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !bank_we |=> $stable(bank_q));

  assert_busreq_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !busreq_we |=> $stable(busreq_q));

  assert_zreset_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !zreset_we |=> $stable(zreset_q));

endmodule

// File: rtl/cwd_top.sv
module cwd_top
  import cwd_pkg::*;
#(
  parameter int DW      = 8,
  parameter int AW      = 16,
  parameter int PORTS   = 16,
  localparam int PIW    = $clog2(PORTS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] acc_addr,
  input  logic          acc_rd,
  input  logic          acc_wr,
  input  logic [DW-1:0] acc_wdata,
  input  logic          cfg_force_ack,
  input  logic          cfg_bootrom_en,
  input  logic          tmr_present,
  input  logic [2*DW-1:0] tmr_value,
  output logic [DW-1:0] acc_rdata,
  output logic          tmr_wr_stb,
  output logic          busreq_o,
  output logic          zreset_o,
  output logic          bank_o,
  output logic          lockup_o
);

  localparam logic [DW-1:0] OPEN_BUS = '1;

  // Reset: asserted asynchronously, released after two clock edges.
  logic [1:0] rst_pipe;
  logic       rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_q = rst_pipe[1];

  slot_e   slot;
  logic    io_rd_ok, io_we, busreq_we, zreset_we, bank_we, tmr_we, lock_req;
  logic [DW-1:0] io_q;

  cwd_decode u_dec (
    .sel            (acc_addr[15:8]),
    .sub            (acc_addr[7:5]),
    .lane_odd       (acc_addr[0]),
    .rd_en          (acc_rd),
    .wr_en          (acc_wr),
    .cfg_force_ack  (cfg_force_ack),
    .cfg_bootrom_en (cfg_bootrom_en),
    .slot           (slot),
    .io_rd_ok       (io_rd_ok),
    .io_we          (io_we),
    .busreq_we      (busreq_we),
    .zreset_we      (zreset_we),
    .bank_we        (bank_we),
    .tmr_we         (tmr_we),
    .lock_req       (lock_req)
  );

  cwd_ioregs #(.DW(DW), .DEPTH(PORTS)) u_io (
    .clk     (clk),
    .rst_n   (rst_q),
    .we      (io_we),
    .wr_idx  (acc_addr[PIW:1]),
    .wr_data (acc_wdata),
    .rd_idx  (acc_addr[PIW:1]),
    .rd_q    (io_q)
  );

  cwd_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_q),
    .busreq_we (busreq_we),
    .zreset_we (zreset_we),
    .bank_we   (bank_we),
    .lock_req  (lock_req),
    .wr_bit    (acc_wdata[0]),
    .busreq_q  (busreq_o),
    .zreset_q  (zreset_o),
    .bank_q    (bank_o),
    .lockup_q  (lockup_o)
  );

  assign tmr_wr_stb = tmr_we;

  always_comb begin
    acc_rdata = OPEN_BUS;
    if (acc_rd) begin
      case (slot)
        SLOT_IO:    if (io_rd_ok) acc_rdata = io_q;
        SLOT_TIMER: if (tmr_present)
                      acc_rdata = acc_addr[0] ? tmr_value[DW-1:0] : tmr_value[2*DW-1:DW];
        SLOT_BOOT:  if (acc_addr[0]) acc_rdata = {OPEN_BUS[DW-1:1], bank_o};
        default:    acc_rdata = OPEN_BUS;
      endcase
    end
  end

  assert_idle_bus_R10: assert property (@(posedge clk) disable iff (!rst_q)
    !acc_rd |-> acc_rdata == OPEN_BUS);

  assert_lock_sticky_R1: assert property (@(posedge clk) disable iff (!rst_q)
    lockup_o |=> lockup_o);

  assert_force_ack_R2: assert property (@(posedge clk) disable iff (!rst_q)
    (cfg_force_ack && !lockup_o) |=> !lockup_o);

  assert_unused_open_R9: assert property (@(posedge clk) disable iff (!rst_q)
    (acc_rd && slot == SLOT_UNUSED) |-> acc_rdata == OPEN_BUS);

  assert_unused_nolock_R9: assert property (@(posedge clk) disable iff (!rst_q)
    (slot == SLOT_UNUSED && !lockup_o) |=> !lockup_o);

endmodule

// File: tb/sim_cwd_top.sv
module sim_cwd_top;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 19;

  logic        clk, rst_n;
  logic [15:0] acc_addr;
  logic        acc_rd, acc_wr;
  logic [7:0]  acc_wdata;
  logic        cfg_force_ack, cfg_bootrom_en, tmr_present;
  logic [15:0] tmr_value;
  logic [7:0]  acc_rdata;
  logic        tmr_wr_stb, busreq_o, zreset_o, bank_o, lockup_o;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  cwd_top u0 (
    .clk(clk), .rst_n(rst_n), .acc_addr(acc_addr), .acc_rd(acc_rd), .acc_wr(acc_wr),
    .acc_wdata(acc_wdata), .cfg_force_ack(cfg_force_ack), .cfg_bootrom_en(cfg_bootrom_en),
    .tmr_present(tmr_present), .tmr_value(tmr_value), .acc_rdata(acc_rdata),
    .tmr_wr_stb(tmr_wr_stb), .busreq_o(busreq_o), .zreset_o(zreset_o), .bank_o(bank_o),
    .lockup_o(lockup_o)
  );

  initial clk = 0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // vector: wr(1) addr(16) data(8) expected read(8); a write vector has no read check
  localparam logic [32:0] VEC [NVEC] = '{
    {1'b1, 16'h0003, 8'h3C, 8'h00},   // R4 odd-lane write port 1
    {1'b0, 16'h0002, 8'h00, 8'h3C},   // R3 read port 1 on even lane
    {1'b1, 16'h0002, 8'h99, 8'h00},   // R4 even-lane write ignored
    {1'b0, 16'h0003, 8'h00, 8'h3C},   // R4
    {1'b1, 16'h0021, 8'h77, 8'h00},   // R4 bit5 set, ignored
    {1'b0, 16'h0001, 8'h00, 8'h00},   // R4 port 0 untouched
    {1'b0, 16'h0021, 8'h00, 8'hFF},   // R3 sub-field nonzero reads open bus
    {1'b1, 16'h001F, 8'h5A, 8'h00},   // R4 port 15
    {1'b0, 16'h001E, 8'h00, 8'h5A},   // R3
    {1'b0, 16'h1100, 8'h00, 8'hFF},   // R5
    {1'b0, 16'h1101, 8'h00, 8'hFF},   // R5
    {1'b0, 16'h3000, 8'h00, 8'hA5},   // R7 high byte
    {1'b0, 16'h3001, 8'h00, 8'h5A},   // R7 low byte
    {1'b1, 16'h4101, 8'h01, 8'h00},   // R8 bank set
    {1'b0, 16'h4101, 8'h00, 8'hFF},   // R8
    {1'b0, 16'h4100, 8'h00, 8'hFF},   // R8 even lane
    {1'b1, 16'h4101, 8'hFE, 8'h00},   // R8 bank clear
    {1'b0, 16'h4101, 8'h00, 8'hFE},   // R8
    {1'b0, 16'h5001, 8'h00, 8'hFF}    // R9
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    acc_addr = a; acc_wdata = d; acc_wr = 1; acc_rd = 0;
    @(negedge clk);
    acc_wr = 0;
  endtask

  task automatic rd(input logic [15:0] a, input string req, input logic [7:0] exp);
    @(negedge clk);
    acc_addr = a; acc_rd = 1; acc_wr = 0;
    #1 chk(req, {8'h0, acc_rdata}, {8'h0, exp});
    @(negedge clk);
    acc_rd = 0;
  endtask

  initial begin
    rst_n = 0; acc_addr = 0; acc_rd = 0; acc_wr = 0; acc_wdata = 0;
    cfg_force_ack = 0; cfg_bootrom_en = 1; tmr_present = 1; tmr_value = 16'hA55A;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R10 reset state
    chk("R10 busreq", {15'h0, busreq_o}, 16'h0);
    chk("R10 zreset", {15'h0, zreset_o}, 16'h0);
    chk("R10 bank",   {15'h0, bank_o},   16'h0);
    chk("R10 lockup", {15'h0, lockup_o}, 16'h0);
    chk("R10 idle rdata", {8'h0, acc_rdata}, 16'h00FF);
    rd(16'h0003, "R10 port reset", 8'h00);

    for (int i = 0; i < NVEC; i++) begin
      if (VEC[i][32]) wr(VEC[i][31:16], VEC[i][15:8]);
      else            rd(VEC[i][31:16], "R3/R4/R5/R7/R8/R9 table", VEC[i][7:0]);
    end

    // R9 unused writes: no alias, no lockup
    wr(16'h1003, 8'h11);
    wr(16'h4400, 8'h22);
    rd(16'h0002, "R9 no alias", 8'h3C);
    rd(16'h2000, "R9 read", 8'hFF);
    chk("R9 no lockup", {15'h0, lockup_o}, 16'h0);

    // R5 bus request
    wr(16'h1100, 8'h01);
    chk("R5 set", {15'h0, busreq_o}, 16'h1);
    wr(16'h1101, 8'h00);
    chk("R5 odd ignored", {15'h0, busreq_o}, 16'h1);
    wr(16'h1100, 8'h02);
    chk("R5 bit0 only", {15'h0, busreq_o}, 16'h0);

    // R6 reset control
    wr(16'h1200, 8'hFF);
    chk("R6 set", {15'h0, zreset_o}, 16'h1);
    wr(16'h1201, 8'h00);
    chk("R6 odd ignored", {15'h0, zreset_o}, 16'h1);
    rd(16'h1200, "R6 read", 8'hFF);

    // R8 bank guard
    cfg_bootrom_en = 0;
    wr(16'h4101, 8'h01);
    rd(16'h4101, "R8 disabled", 8'hFE);
    cfg_bootrom_en = 1;
    wr(16'h4100, 8'h01);
    chk("R8 even ignored", {15'h0, bank_o}, 16'h0);

    // R7 absent device and write strobe
    tmr_present = 0;
    rd(16'h3000, "R7 absent", 8'hFF);
    @(negedge clk);
    acc_addr = 16'h3001; acc_wr = 1;
    #1 chk("R7 strobe", {15'h0, tmr_wr_stb}, 16'h1);
    @(negedge clk);
    acc_wr = 0;
    #1 chk("R7 strobe low", {15'h0, tmr_wr_stb}, 16'h0);

    // R11 same-cycle read and write
    @(negedge clk);
    acc_addr = 16'h0005; acc_wdata = 8'hC3; acc_rd = 1; acc_wr = 1;
    #1 chk("R11 old value", {8'h0, acc_rdata}, 16'h0000);
    @(negedge clk);
    acc_rd = 0; acc_wr = 0;
    rd(16'h0004, "R11 new value", 8'hC3);

    // R2 forced acknowledge
    cfg_force_ack = 1;
    rd(16'h1300, "R2 read", 8'hFF);
    wr(16'hFF00, 8'h00);
    chk("R2 no lockup", {15'h0, lockup_o}, 16'h0);

    // R1 lockup, sticky
    cfg_force_ack = 0;
    rd(16'h1300, "R1 read", 8'hFF);
    chk("R1 lockup", {15'h0, lockup_o}, 16'h1);
    repeat (5) @(negedge clk);
    chk("R1 sticky", {15'h0, lockup_o}, 16'h1);

    // R10 reset clears everything
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk("R10 lockup cleared", {15'h0, lockup_o}, 16'h0);
    chk("R10 zreset cleared", {15'h0, zreset_o}, 16'h0);
    rd(16'h0002, "R10 port cleared", 8'h00);

    done = 1;
  end

  initial begin
    for (int c = 0; c < 5000 && !done; c++) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule